// File: doc/BRIEF.md
# Fixed-Point Programmable-Increment Time Counter

This block keeps a free-running 64-bit system time value. It does not count whole nanoseconds. On each active reference-clock tick it adds a programmable fixed-point step, so the lower bits of the count hold a binary fraction. Host software chooses the step from the link rate. At 10G or with no link the reference tick is 6.4 ns, at 1G it is ten times longer and at 100M it is one hundred times longer. Software can rewrite the step at any time to trim the frequency. Host software converts the count to nanoseconds with a right shift, and that shift is not done here.

The default build is the narrow variant. The step field is 24 bits wide, and the bits above it hold an add period. Software normally writes the period as 1. When the period is N, the step is added once every N ticks. Software reads the time as two 32-bit halves. A read of the low half freezes a copy of the high half, so a later read of the high half returns a value that belongs to the same instant.

Top module: `tc_time_counter`

## Requirements
- R1: After reset the count is 0, the snapshot copy of the high half is 0, and the increment register holds 0x01CCCCCC (step 0xCCCCCC, period 1).
- R2: On every cycle where an add is due and no time half is written, the 64-bit count grows by the step field, which is bits [INC_W-1:0] of the increment register.
- R3: The register offsets are: 0 for the low time half, 1 for the high time half, and 2 for the increment register. In the increment register, the step sits in bits [INC_W-1:0] and the period sits in bits [31:INC_W]. Reading offset 2 returns the whole register.
- R4: With a period field of N > 1, an add happens once every N cycles, and a period of 0 acts as 1. A write to the increment register restarts the phase, so the first add comes N cycles after the write.
- R5: A write to the increment register leaves the accumulated count untouched. The new step is used from the next add onward. An add that falls in the write cycle still uses the old step.
- R6: A read of offset 0 returns the live low half and copies the live high half into the snapshot copy. A read of offset 1 returns that copy, not the live high half.
- R7: A write to offset 0 or 1 replaces that half and keeps the other half. No add is applied in that cycle. Writing zero to both halves clears the count.
- R8: The count wraps modulo 2^64 with no flag.
- R9: Offset 3 reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on offset 0) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from offset |

## Verification
Two collisions matter here. The first is a time-half write that lands on a cycle where an add is due, so the bench must confirm that the add is dropped rather than applied. The second is an increment write that lands on an add cycle, which must use the old step and then restart the phase. Both cases are provoked by issuing register writes while the period field is 1, so that every cycle is an add cycle. A behavioural model in the bench recomputes the count, the phase and the snapshot copy. It compares the read data each cycle, which exposes any wrong step, lost add or extra add in the next low-half value.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TC_OFS_LO   = 2'd0,
    TC_OFS_HI   = 2'd1,
    TC_OFS_INC  = 2'd2,
    TC_OFS_RSVD = 2'd3
  } tc_ofs_e;

  // one accumulation step, wrapping modulo 2^64
  function automatic logic [63:0] tc_advance(input logic [63:0] t, input logic [63:0] step);
    return t + step;
  endfunction

  // replace one 32-bit half of the time value, keeping the other
  function automatic logic [63:0] tc_load_half(input logic [63:0] t, input logic sel_hi,
                                               input logic [31:0] d);
    return sel_hi ? {d, t[31:0]} : {t[63:32], d};
  endfunction
endpackage

// File: rtl/tc_incr_reg.sv
module tc_incr_reg #(
  parameter int unsigned RST_VAL = 32'h01CC_CCCC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] incr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     incr_q <= RST_VAL;
    else if (wr_en) incr_q <= wdata;
  end
endmodule

// File: rtl/tc_tick_div.sv
module tc_tick_div #(
  parameter int unsigned INC_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic [31:0] incr_q,
  output logic        fire
);
  generate
    if (INC_W >= 32) begin : g_no_period
      assign fire = 1'b1;
    end else begin : g_period
      localparam int unsigned PER_W = 32 - INC_W;
      logic [PER_W-1:0] per_field;
      logic [PER_W-1:0] per_last;
      logic [PER_W-1:0] phase_q;
      assign per_field = incr_q[31:INC_W];
      assign per_last  = (per_field == '0) ? '0 : per_field - 1'b1;
      assign fire      = (phase_q == per_last);
      always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (restart || fire)  phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tc_accum.sv
module tc_accum
  import tc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        fire,
  input  logic [63:0] step,
  input  logic        snap,
  output logic [63:0] time_q,
  output logic [31:0] shadow_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_lo || wr_hi) time_q <= tc_load_half(time_q, wr_hi, wdata);
      else if (fire)      time_q <= tc_advance(time_q, step);
      if (snap)           shadow_q <= time_q[63:32];
    end
  end
endmodule

// File: rtl/tc_time_counter.sv
module tc_time_counter
  import tc_pkg::*;
#(
  parameter int unsigned INC_W   = 24,
  parameter int unsigned RST_INC = 32'h01CC_CCCC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int unsigned STEP_PAD = 64 - INC_W;

  tc_ofs_e     ofs;
  logic        wr_lo, wr_hi, wr_inc, rd_lo;
  logic        fire;
  logic [31:0] incr_q;
  logic [63:0] step;
  logic [63:0] time_q;
  logic [31:0] shadow_q;

  assign ofs    = tc_ofs_e'(reg_addr);
  assign wr_lo  = reg_wr && (ofs == TC_OFS_LO);
  assign wr_hi  = reg_wr && (ofs == TC_OFS_HI);
  assign wr_inc = reg_wr && (ofs == TC_OFS_INC);
  assign rd_lo  = reg_rd && (ofs == TC_OFS_LO);
  assign step   = {{STEP_PAD{1'b0}}, incr_q[INC_W-1:0]};

  tc_incr_reg #(.RST_VAL(RST_INC)) u_incr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_inc), .wdata(reg_wdata), .incr_q(incr_q)
  );

  tc_tick_div #(.INC_W(INC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(wr_inc), .incr_q(incr_q), .fire(fire)
  );

  tc_accum u_acc (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata),
    .fire(fire), .step(step), .snap(rd_lo), .time_q(time_q), .shadow_q(shadow_q)
  );

  always_comb begin
    unique case (ofs)
      TC_OFS_LO:  reg_rdata = time_q[31:0];
      TC_OFS_HI:  reg_rdata = shadow_q;
      TC_OFS_INC: reg_rdata = incr_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tc_time_counter_chk.sv
module tc_time_counter_chk #(
  parameter int unsigned INC_W = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic        wr_inc,
  input logic        rd_lo,
  input logic        fire,
  input logic [31:0] reg_wdata,
  input logic [31:0] incr_q,
  input logic [63:0] step,
  input logic [63:0] time_q,
  input logic [31:0] shadow_q
);
  logic per_gt1;
  assign per_gt1 = ((incr_q >> INC_W) > 32'd1);

  // R2 / R8: an add cycle grows the count by the step, wrapping
  a_r2_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_lo && !wr_hi) |=> (time_q == $past(time_q) + $past(step)));

  // R4: no change of count on cycles without an add or write
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !wr_lo && !wr_hi) |=> $stable(time_q));

  // R4: with period above one, adds never come back to back
  a_r4_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_gt1 && !wr_inc) |=> !fire);

  // R6: low read freezes the high half
  a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow_q == $past(time_q[63:32])));

  // R7: low write loads low half, keeps high half
  a_r7_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (time_q[31:0] == $past(reg_wdata) &&
                           time_q[63:32] == $past(time_q[63:32])));

  // R5: increment write leaves count as the old step would
  a_r5_incr_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inc && !fire) |=> $stable(time_q));
endmodule

bind tc_time_counter tc_time_counter_chk #(.INC_W(INC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_inc(wr_inc),
  .rd_lo(rd_lo), .fire(fire), .reg_wdata(reg_wdata), .incr_q(incr_q),
  .step(step), .time_q(time_q), .shadow_q(shadow_q)
);

// File: tb/tc_time_counter_tb.sv
module tc_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int fails = 0;

  // behavioural reference state
  longint unsigned m_time;
  int unsigned     m_incr;
  int unsigned     m_shadow;
  int unsigned     m_phase;

  always #5 clk = ~clk;

  tc_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic int unsigned model_read(input logic [1:0] a);
    case (a)
      2'd0:    return int'(m_time & 64'hFFFF_FFFF);
      2'd1:    return m_shadow;
      2'd2:    return m_incr;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare read data, step the model at the edge
  task automatic cyc(input bit wr, input bit rd, input logic [1:0] a,
                     input logic [31:0] d, input string req);
    int unsigned per, step;
    bit add_due;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
    check(req, reg_rdata, model_read(a));
    @(posedge clk);
    per     = m_incr >> 24;
    if (per == 0) per = 1;
    step    = m_incr & 32'h00FF_FFFF;
    add_due = (m_phase == per - 1);
    if (rd && a == 2'd0) m_shadow = int'(m_time >> 32);
    if (wr && a == 2'd0)      m_time = (m_time & 64'hFFFF_FFFF_0000_0000) | longint'(d);
    else if (wr && a == 2'd1) m_time = (m_time & 64'h0000_0000_FFFF_FFFF) | (longint'(d) << 32);
    else if (add_due)         m_time = m_time + longint'(step);
    if (wr && a == 2'd2) begin m_incr = d; m_phase = 0; end
    else if (add_due)    m_phase = 0;
    else                 m_phase = m_phase + 1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0, req);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    m_time = 0; m_incr = 32'h01CC_CCCC; m_shadow = 0; m_phase = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, read without side effects
    cyc(1'b0, 1'b0, 2'd2, 32'h0, "R1");
    cyc(1'b0, 1'b0, 2'd1, 32'h0, "R1");
    // R2: default step accumulation
    idle(12, "R2");
    // R5: trim step while adds are due every cycle
    cyc(1'b1, 1'b0, 2'd2, 32'h0100_0100, "R5");
    idle(6, "R5");
    cyc(1'b0, 1'b0, 2'd2, 32'h0, "R3");
    // R4: period three, then period zero acting as one
    cyc(1'b1, 1'b0, 2'd2, 32'h0300_0010, "R4");
    idle(10, "R4");
    cyc(1'b1, 1'b0, 2'd2, 32'h0000_0020, "R4");
    idle(5, "R4");
    // R7: load low half near a carry while an add is due
    cyc(1'b1, 1'b0, 2'd2, 32'h0100_0010, "R5");
    cyc(1'b1, 1'b0, 2'd0, 32'hFFFF_FFE0, "R7");
    // R6: snapshot, then let the carry ripple into the live high half
    cyc(1'b0, 1'b1, 2'd0, 32'h0, "R6");
    idle(4, "R6");
    cyc(1'b0, 1'b0, 2'd1, 32'h0, "R6");
    cyc(1'b0, 1'b1, 2'd0, 32'h0, "R6");
    cyc(1'b0, 1'b0, 2'd1, 32'h0, "R6");
    // R8: wrap past 2^64
    cyc(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF, "R7");
    cyc(1'b1, 1'b0, 2'd0, 32'hFFFF_FFE8, "R7");
    idle(3, "R8");
    cyc(1'b0, 1'b1, 2'd0, 32'h0, "R8");
    cyc(1'b0, 1'b0, 2'd1, 32'h0, "R8");
    // R9: reserved offset
    cyc(1'b1, 1'b0, 2'd3, 32'hDEAD_BEEF, "R9");
    cyc(1'b0, 1'b0, 2'd3, 32'h0, "R9");
    cyc(1'b0, 1'b0, 2'd2, 32'h0, "R9");
    // R7: clear with zero writes to both halves
    cyc(1'b1, 1'b0, 2'd2, 32'h0200_0004, "R4");
    cyc(1'b1, 1'b0, 2'd0, 32'h0, "R7");
    cyc(1'b1, 1'b0, 2'd1, 32'h0, "R7");
    cyc(1'b0, 1'b1, 2'd0, 32'h0, "R7");
    cyc(1'b0, 1'b0, 2'd1, 32'h0, "R7");
    idle(6, "R4");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule